// File: doc/BRIEF.md
# Dual-Channel Converter Input Front End

This block sits between a sample source and a pair of converter cores. It accepts parallel sample words and hands each core a stable code through a two-stage latch per channel: a holding register that takes a new word on a write strobe, followed by an output register that copies the holding register on an update strobe. The output register only changes on an update, so the core never sees a half-written word.

A mode input chooses one of two ways of using the same four strobe pins. In dual-port operation, each channel has its own data bus, its own write strobe and its own update strobe, and the two channels run independently. In interleaved operation, one data bus carries alternating I and Q words. The first write pin captures them. The second write pin becomes a steering select. The first update pin becomes the sample clock. The second update pin becomes a phase reset. An internal divide-by-two of the sample clock loads both output registers on the same edge, so both channels update at half the input word rate. All strobes are sampled on the block clock, and the block acts on their rising edges.

Top module: `dual_dac_front`

## Requirements
- R1: While `rst_n` is low, and after its release until the first update, both output codes are zero and both update flags are low.
- R2: In dual-port mode (`mode_dual` = 1), a rising edge on `wr1_iqwr` stores `port1_data` in the channel-1 holding register, and a rising edge on `wr2_iqsel` stores `port2_data` in the channel-2 holding register. Neither write changes an output code.
- R3: In dual-port mode, a rising edge on `upd1_iqclk` copies the channel-1 holding register to `dac1_code` and raises `dac1_upd` for exactly one cycle. A rising edge on `upd2_iqrst` does the same for channel 2. Each channel's update leaves the other channel untouched.
- R4: `mode_dual` = 0 selects interleaved operation, and `mode_dual` = 1 selects dual-port operation.
- R5: In interleaved mode, a rising edge on `wr1_iqwr` captures `port1_data`. It goes to channel 1 when `wr2_iqsel` is 1 and to channel 2 when it is 0. `port2_data` has no effect.
- R6: In interleaved mode, both output registers load on every second rising edge of `upd1_iqclk`. They load on the same cycle, and `dac1_upd` and `dac2_upd` pulse together.
- R7: In interleaved mode, while `upd2_iqrst` is high the divider is held at phase zero and no load occurs. After release, the first rising edge of `upd1_iqclk` does not load, and the second one loads.
- R8: Several writes to one holding register before an update leave only the last word. The update delivers that last word.
- R9: An output code holds its value in every cycle without an update.
- R10: Codes are straight binary of `WIDTH` bits (default 10), with bit 0 as the LSB. A word reaches the output bit for bit, unchanged.
- R11: A strobe held high for several cycles counts as a single edge. A write held high captures only the word present on its first high cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_dual | input | 1 | 1: dual-port operation, 0: interleaved operation |
| port1_data | input | WIDTH | Channel-1 data, or the interleaved I/Q stream |
| port2_data | input | WIDTH | Channel-2 data in dual-port mode; ignored when interleaved |
| wr1_iqwr | input | 1 | Channel-1 write, or the interleaved write |
| upd1_iqclk | input | 1 | Channel-1 update, or the interleaved sample clock |
| wr2_iqsel | input | 1 | Channel-2 write, or the I/Q steering select (1 = channel 1) |
| upd2_iqrst | input | 1 | Channel-2 update, or the divider phase reset (active high) |
| dac1_code | output | WIDTH | Channel-1 output register |
| dac2_code | output | WIDTH | Channel-2 output register |
| dac1_upd | output | 1 | One-cycle pulse after dac1_code has loaded |
| dac2_upd | output | 1 | One-cycle pulse after dac2_code has loaded |

## Verification
The assertions take two things for granted. First, `mode_dual` stays steady across a burst of traffic. Second, every strobe is a level that stays valid for at least one full block-clock cycle, so that each edge is seen exactly once. The stimulus meets both conditions. It changes the mode only between bursts, while all strobes are low. It drives every strobe on the falling clock edge, high for at least one whole cycle and then low for at least one. In interleaved mode, the select and phase-reset levels are set up before the write or sample-clock edge that uses them, and `port2_data` is driven with unrelated words to show that it is ignored.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  typedef enum logic {
    MODE_IQ   = 1'b0,
    MODE_DUAL = 1'b1
  } port_mode_e;

  localparam int unsigned N_STROBES = 4;
  localparam int unsigned S_WR1  = 0;
  localparam int unsigned S_UPD1 = 1;
  localparam int unsigned S_WR2  = 2;
  localparam int unsigned S_UPD2 = 3;
endpackage

// File: rtl/strobe_rise.sv
module strobe_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign rise = lvl & ~prev_q;

  // R11: a level held high yields no second edge
  assert_single_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/chan_latch.sv
module chan_latch #(
  parameter int unsigned WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             upd_en,
  output logic [WIDTH-1:0] dac_q,
  output logic             upd_q
);
  logic [WIDTH-1:0] hold_q, hold_d;
  logic [WIDTH-1:0] dac_d;
  logic             upd_d;

  always_comb begin
    hold_d = hold_q;
    if (wr_en) hold_d = wr_data;
    dac_d = dac_q;
    if (upd_en) dac_d = hold_q;
    upd_d = upd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      dac_q  <= '0;
      upd_q  <= 1'b0;
    end else begin
      if (wr_en)  hold_q <= hold_d;
      if (upd_en) dac_q  <= dac_d;
      upd_q <= upd_d;
    end
  end

  assert_hold_without_update_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(dac_q));
  assert_update_copies_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (dac_q == $past(hold_q)) && upd_q);
endmodule

// File: rtl/iq_phase.sv
module iq_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic iq_mode,
  input  logic tick,
  input  logic clr,
  output logic load
);
  logic phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (!iq_mode || clr) phase_d = 1'b0;
    else if (tick)       phase_d = ~phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_d;
  end

  assign load = iq_mode & ~clr & tick & phase_q;

  assert_half_rate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !load);
  assert_reset_aligns_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (iq_mode && clr) |=> !phase_q);
endmodule

// File: rtl/dual_dac_front.sv
module dual_dac_front #(
  parameter int unsigned WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_dual,
  input  logic [WIDTH-1:0] port1_data,
  input  logic [WIDTH-1:0] port2_data,
  input  logic             wr1_iqwr,
  input  logic             upd1_iqclk,
  input  logic             wr2_iqsel,
  input  logic             upd2_iqrst,
  output logic [WIDTH-1:0] dac1_code,
  output logic [WIDTH-1:0] dac2_code,
  output logic             dac1_upd,
  output logic             dac2_upd
);
  import dacif_pkg::*;

  port_mode_e                 mode;
  logic [N_STROBES-1:0]       strobe_lvl;
  logic [N_STROBES-1:0]       strobe_rise_w;
  logic                       iq_load;
  logic                       wr_en1, wr_en2, upd_en1, upd_en2;
  logic [WIDTH-1:0]           data2_sel;

  assign mode = port_mode_e'(mode_dual);

  assign strobe_lvl[S_WR1]  = wr1_iqwr;
  assign strobe_lvl[S_UPD1] = upd1_iqclk;
  assign strobe_lvl[S_WR2]  = wr2_iqsel;
  assign strobe_lvl[S_UPD2] = upd2_iqrst;

  for (genvar g = 0; g < N_STROBES; g++) begin : g_edge
    strobe_rise u_rise (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (strobe_lvl[g]),
      .rise  (strobe_rise_w[g])
    );
  end

  iq_phase u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .iq_mode (mode == MODE_IQ),
    .tick    (strobe_rise_w[S_UPD1]),
    .clr     (upd2_iqrst),
    .load    (iq_load)
  );

  always_comb begin
    if (mode == MODE_DUAL) begin
      wr_en1    = strobe_rise_w[S_WR1];
      wr_en2    = strobe_rise_w[S_WR2];
      data2_sel = port2_data;
      upd_en1   = strobe_rise_w[S_UPD1];
      upd_en2   = strobe_rise_w[S_UPD2];
    end else begin
      wr_en1    = strobe_rise_w[S_WR1] &  wr2_iqsel;
      wr_en2    = strobe_rise_w[S_WR1] & ~wr2_iqsel;
      data2_sel = port1_data;
      upd_en1   = iq_load;
      upd_en2   = iq_load;
    end
  end

  chan_latch #(.WIDTH(WIDTH)) u_ch1 (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en1),
    .wr_data (port1_data),
    .upd_en  (upd_en1),
    .dac_q   (dac1_code),
    .upd_q   (dac1_upd)
  );

  chan_latch #(.WIDTH(WIDTH)) u_ch2 (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en2),
    .wr_data (data2_sel),
    .upd_en  (upd_en2),
    .dac_q   (dac2_code),
    .upd_q   (dac2_upd)
  );

  assert_iq_updates_paired_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_IQ && $past(mode == MODE_IQ)) |-> (dac1_upd == dac2_upd));
  assert_iq_no_direct_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_IQ && strobe_rise_w[S_UPD2]) |=> !dac2_upd || dac1_upd);
endmodule

// File: tb/test_dual_dac_front.sv
module test_dual_dac_front;
  localparam int CLK_PERIOD = 10;
  localparam int W = 10;

  logic clk, rst_n, mode_dual;
  logic [W-1:0] port1_data, port2_data;
  logic wr1_iqwr, upd1_iqclk, wr2_iqsel, upd2_iqrst;
  logic [W-1:0] dac1_code, dac2_code;
  logic dac1_upd, dac2_upd;

  dual_dac_front #(.WIDTH(W)) i_dual_dac_front (
    .clk(clk), .rst_n(rst_n), .mode_dual(mode_dual),
    .port1_data(port1_data), .port2_data(port2_data),
    .wr1_iqwr(wr1_iqwr), .upd1_iqclk(upd1_iqclk),
    .wr2_iqsel(wr2_iqsel), .upd2_iqrst(upd2_iqrst),
    .dac1_code(dac1_code), .dac2_code(dac2_code),
    .dac1_upd(dac1_upd), .dac2_upd(dac2_upd)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int vecs = 0;
  int errs = 0;
  bit done = 0;
  logic [W-1:0] m_in1, m_in2, m_dac1, m_dac2;
  bit m_phase;

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req, bit e1, bit e2);
    chk(req, dac1_code, m_dac1);
    chk(req, dac2_code, m_dac2);
    chk(req, W'(dac1_upd), W'(e1));
    chk(req, W'(dac2_upd), W'(e2));
  endtask

  // dual-port write, R2: outputs untouched
  task automatic dual_write(int ch, int val);
    if (ch == 1) begin port1_data = W'(val); wr1_iqwr = 1'b1; m_in1 = W'(val); end
    else         begin port2_data = W'(val); wr2_iqsel = 1'b1; m_in2 = W'(val); end
    @(negedge clk);
    wr1_iqwr = 1'b0; wr2_iqsel = 1'b0;
    @(negedge clk);
    chk_all("R2 write leaves outputs", 1'b0, 1'b0);
  endtask

  // dual-port update, R3 and R9
  task automatic dual_update(int ch);
    if (ch == 1) begin upd1_iqclk = 1'b1; m_dac1 = m_in1; end
    else         begin upd2_iqrst = 1'b1; m_dac2 = m_in2; end
    @(negedge clk);
    chk_all("R3 update loads one channel", ch == 1, ch == 2);
    upd1_iqclk = 1'b0; upd2_iqrst = 1'b0;
    @(negedge clk);
    chk_all("R9 hold after update", 1'b0, 1'b0);
  endtask

  // interleaved write, R5 (port2_data driven with junk)
  task automatic iq_write(bit sel, int val);
    wr2_iqsel = sel;
    port1_data = W'(val);
    port2_data = ~W'(val);
    wr1_iqwr = 1'b1;
    if (sel) m_in1 = W'(val); else m_in2 = W'(val);
    @(negedge clk);
    wr1_iqwr = 1'b0;
    port1_data = W'(val * 3 + 1);
    @(negedge clk);
    chk_all("R5 steered write leaves outputs", 1'b0, 1'b0);
  endtask

  // interleaved sample clock edge, R6 and R7
  task automatic iq_clock();
    bit ld;
    ld = 1'b0;
    if (upd2_iqrst) m_phase = 1'b0;
    else if (m_phase) begin ld = 1'b1; m_phase = 1'b0; m_dac1 = m_in1; m_dac2 = m_in2; end
    else m_phase = 1'b1;
    upd1_iqclk = 1'b1;
    @(negedge clk);
    chk_all(upd2_iqrst ? "R7 no load in phase reset" : "R6 half-rate paired load", ld, ld);
    upd1_iqclk = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_dual = 1'b1;
    port1_data = '0; port2_data = '0;
    wr1_iqwr = 1'b0; upd1_iqclk = 1'b0; wr2_iqsel = 1'b0; upd2_iqrst = 1'b0;
    m_in1 = '0; m_in2 = '0; m_dac1 = '0; m_dac2 = '0; m_phase = 1'b0;
    repeat (3) @(negedge clk);
    chk_all("R1 reset state", 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 after release", 1'b0, 1'b0);

    // R4 dual mode; R10 straight binary sweep including all-zeros and all-ones
    for (int k = 0; k < 24; k++) begin
      int a, b;
      a = (k == 0) ? 0 : (k == 1) ? (1 << W) - 1 : (k * 37 + 5) % (1 << W);
      b = (k == 0) ? (1 << W) - 1 : (k * 91 + 200) % (1 << W);
      dual_write(1, a);
      dual_write(2, b);
      if (k % 2 == 0) begin dual_update(1); dual_update(2); end
      else            begin dual_update(2); dual_update(1); end
      chk("R10 code passes bit for bit", dac1_code, W'(a));
    end

    // R8 last write wins in dual mode
    dual_write(1, 11); dual_write(1, 22); dual_write(1, 333);
    dual_update(1);

    // R11 level held high captures only the first word
    port1_data = W'(100); wr1_iqwr = 1'b1; m_in1 = W'(100);
    @(negedge clk); port1_data = W'(200);
    @(negedge clk); port1_data = W'(300);
    @(negedge clk); wr1_iqwr = 1'b0;
    @(negedge clk);
    dual_update(1);
    chk("R11 held strobe single capture", dac1_code, W'(100));

    // R4 interleaved mode
    mode_dual = 1'b0;
    @(negedge clk);
    upd2_iqrst = 1'b1;
    @(negedge clk);
    iq_clock();
    upd2_iqrst = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 20; k++) begin
      iq_write(1'b1, (k * 53 + 7) % (1 << W));
      iq_write(1'b0, (k * 29 + 400) % (1 << W));
      if (k % 3 == 1) iq_write(1'b0, (k * 11 + 3) % (1 << W));  // R8 same select twice
      if (k % 4 == 2) iq_write(1'b1, (k * 17 + 9) % (1 << W));  // R8
      iq_clock();
      iq_clock();
    end

    // R7 mid-phase reset: one edge, reset, then two edges needed
    iq_write(1'b1, 515);
    iq_write(1'b0, 77);
    iq_clock();
    upd2_iqrst = 1'b1;
    @(negedge clk);
    iq_clock();
    upd2_iqrst = 1'b0;
    @(negedge clk);
    iq_clock();
    iq_clock();
    chk("R7 realigned load ch1", dac1_code, W'(515));
    chk("R7 realigned load ch2", dac2_code, W'(77));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule